// File: doc/BRIEF.md
# Local-to-Remote Bus Window Address Mapper

This block sits on the path from a local bus into a window onto a remote bus. Every local access that falls in the window is split into a page index and a 12-bit offset. The page index selects one 32-bit entry in a mapping table, one entry per 4 KB page. The entry supplies the upper twenty remote address bits. It also supplies a 6-bit address-modifier code, a two-bit access-kind code and three data-lane swap controls. The offset passes through unchanged. Write data and byte enables are reordered across byte lanes as the entry directs. Read data that comes back from the remote side is reordered the same way before it is handed to the local side.

The table is loaded and inspected through a simple indexed write/read port. An entry with bit 0 set is invalid, and an access through it never reaches the remote bus. Instead the block raises a one-cycle error pulse, returns all-ones data when the access was a read, and sets a sticky error flag that stays up until software clears it. The table depth is a parameter (default 1024 entries, index taken from local address bits 12 upward). The table is not reset, so software must write every entry it intends to use.

Top module: `wmap_top`

## Requirements
- R1: The remote address is formed from entry bits 31..12 followed by local address bits 11..0; the entry is the one indexed by local address bits 12+IDX_W-1..12, and local address bits above that field have no effect.
- R2: The translated outputs (rmt_valid or map_err with rmt_addr, rmt_am, rmt_kind, rmt_write, rmt_be, rmt_wdata) appear exactly one clock after req_valid is sampled; cfg_rdata shows the addressed entry one clock after cfg_rd is sampled.
- R3: An entry with bit 0 = 1 is invalid: for such an access rmt_valid stays 0 and map_err is 1 for one cycle; for a valid entry rmt_valid is 1 and map_err is 0.
- R4: rmt_am carries entry bits 11..6.
- R5: rmt_kind carries entry bits 5..4 (01 remote I/O, 10 remote memory, 11 dual-port RAM).
- R6: Byte lane k is data bits 8k+7..8k. Entry bit 2 exchanges lanes k and k^2 (16-bit halves). Entry bit 3 exchanges lanes k and k^1 (bytes within each half). Entry bit 1 does the same as bit 3, but only when more than one byte enable is set. With both exchanges active, the half exchange is applied first and the byte exchange second. The same reordering applies to write data and byte enables.
- R7: Remote read data given with rmt_rvalid appears on loc_rdata with loc_rvalid one clock later. It is reordered by the lane settings of the most recent valid read.
- R8: A read through an invalid entry raises loc_rvalid in the same cycle as map_err, with loc_rdata all ones.
- R9: err_sticky becomes 1 the clock after map_err and stays 1 until a cycle with err_clr = 1 and no map_err; if map_err and err_clr coincide, the flag remains set.
- R10: A cfg_wr stores cfg_wdata at cfg_idx. A lookup sampled in the same clock as a write to the same index sees the previous contents, and the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Table entry write strobe |
| cfg_rd | input | 1 | Table entry read strobe |
| cfg_idx | input | IDX_W | Table entry index |
| cfg_wdata | input | 32 | Entry value to store |
| cfg_rdata | output | 32 | Entry value read back |
| err_clr | input | 1 | Clears the sticky error flag |
| req_valid | input | 1 | Local access request |
| req_addr | input | 32 | Local window address |
| req_be | input | DATA_W/8 | Local byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Local write data |
| rmt_valid | output | 1 | Translated access issued to remote side |
| map_err | output | 1 | Access hit an invalid entry (pulse) |
| rmt_addr | output | 32 | Remote address |
| rmt_am | output | 6 | Address-modifier code |
| rmt_kind | output | 2 | Access kind code |
| rmt_write | output | 1 | Direction of the translated access |
| rmt_be | output | DATA_W/8 | Lane-reordered byte enables |
| rmt_wdata | output | DATA_W | Lane-reordered write data |
| rmt_rvalid | input | 1 | Remote read data valid |
| rmt_rdata | input | DATA_W | Remote read data |
| loc_rvalid | output | 1 | Read data valid toward local side |
| loc_rdata | output | DATA_W | Read data toward local side |
| err_sticky | output | 1 | Sticky invalid-access flag |

## Verification
The bench goes after the lane orderings. It applies single-byte, halfword and full-word enables under every swap combination. A design that ignored the multi-byte condition, or applied the two exchanges in the wrong order, would scramble data or enables on exactly those patterns. Invalid entries are mixed into random traffic. An access that leaked to the remote side, or a read that returned stale data instead of all ones, is therefore visible. The bench also drives a table write and a lookup of the same page in one clock, which catches a table that forwards new contents early. It drives clear and error together, which catches a flag that lets the clear win.

// File: rtl/wmap_pkg.sv
package wmap_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_SH  = 12;
  localparam int FRAME_W  = ADDR_W - PAGE_SH;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_IO    = 2'b01,
    KIND_MEM   = 2'b10,
    KIND_DPRAM = 2'b11
  } kind_e;

  // bit positions are fixed by software's view of an entry
  typedef struct packed {
    logic [FRAME_W-1:0] frame;   // 31..12
    logic [5:0]         am;      // 11..6
    kind_e              kind;    // 5..4
    logic               bswap;   // 3
    logic               hswap;   // 2
    logic               mbswap;  // 1
    logic               inval;   // 0
  } entry_t;
endpackage

// File: rtl/wmap_table.sv
module wmap_table #(
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  wmap_pkg::entry_t     cfg_wdata,
  output wmap_pkg::entry_t     cfg_rdata,
  input  logic                 lk_en,
  input  logic [IDX_W-1:0]     lk_idx,
  output wmap_pkg::entry_t     lk_entry
);
  localparam int DEPTH = 1 << IDX_W;

  wmap_pkg::entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_wr) begin
      mem[cfg_idx] <= cfg_wdata;
    end
  end

  // lookup read: old contents when a write hits the same index
  always_ff @(posedge clk) begin
    if (lk_en) begin
      lk_entry <= mem[lk_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_rd) begin
      cfg_rdata <= mem[cfg_idx];
    end
  end
endmodule

// File: rtl/wmap_swap.sv
module wmap_swap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   d_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic                bs_i,
  input  logic                hs_i,
  output logic [DATA_W-1:0]   d_o,
  output logic [DATA_W/8-1:0] be_o
);
  localparam int LANES = DATA_W / 8;
  localparam int HALF  = LANES / 2;

  logic [DATA_W-1:0] d_h;
  logic [LANES-1:0]  be_h;

  // stage 1: half exchange, stage 2: byte exchange inside each 16-bit unit
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HSRC = (k + HALF) % LANES;
    localparam int BSRC = (k % 2 == 0) ? k + 1 : k - 1;
    always_comb begin
      d_h[8*k +: 8] = hs_i ? d_i[8*HSRC +: 8] : d_i[8*k +: 8];
      be_h[k]       = hs_i ? be_i[HSRC] : be_i[k];
      d_o[8*k +: 8] = bs_i ? d_h[8*BSRC +: 8] : d_h[8*k +: 8];
      be_o[k]       = bs_i ? be_h[BSRC] : be_h[k];
    end
  end

  always_comb begin
    AST_BE_COUNT: assert ($countones(be_o) == $countones(be_i)); // R6
  end
endmodule

// File: rtl/wmap_err_flag.sv
module wmap_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R9
endmodule

// File: rtl/wmap_top.sv
module wmap_top #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                err_clr,
  input  logic                req_valid,
  input  logic [31:0]         req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rmt_valid,
  output logic                map_err,
  output logic [31:0]         rmt_addr,
  output logic [5:0]          rmt_am,
  output logic [1:0]          rmt_kind,
  output logic                rmt_write,
  output logic [DATA_W/8-1:0] rmt_be,
  output logic [DATA_W-1:0]   rmt_wdata,
  input  logic                rmt_rvalid,
  input  logic [DATA_W-1:0]   rmt_rdata,
  output logic                loc_rvalid,
  output logic [DATA_W-1:0]   loc_rdata,
  output logic                err_sticky
);
  import wmap_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int IDX_LO = PAGE_SH;
  localparam int IDX_HI = PAGE_SH + IDX_W - 1;

  entry_t cfg_ent_r;
  entry_t ent;

  wmap_table #(.IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (entry_t'(cfg_wdata)),
    .cfg_rdata (cfg_ent_r),
    .lk_en     (req_valid),
    .lk_idx    (req_addr[IDX_HI:IDX_LO]),
    .lk_entry  (ent)
  );
  assign cfg_rdata = 32'(cfg_ent_r);

  logic unused_hi;
  assign unused_hi = ^req_addr[31:IDX_HI+1];

  // request stage
  logic               s_vld_q, s_vld_d;
  logic [PAGE_SH-1:0] s_off_q, s_off_d;
  logic [LANES-1:0]   s_be_q,  s_be_d;
  logic               s_wr_q,  s_wr_d;
  logic [DATA_W-1:0]  s_wd_q,  s_wd_d;

  always_comb begin
    s_vld_d = req_valid;
    s_off_d = req_valid ? req_addr[PAGE_SH-1:0] : s_off_q;
    s_be_d  = req_valid ? req_be    : s_be_q;
    s_wr_d  = req_valid ? req_write : s_wr_q;
    s_wd_d  = req_valid ? req_wdata : s_wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld_q <= 1'b0;
      s_off_q <= '0;
      s_be_q  <= '0;
      s_wr_q  <= 1'b0;
      s_wd_q  <= '0;
    end else begin
      s_vld_q <= s_vld_d;
      s_off_q <= s_off_d;
      s_be_q  <= s_be_d;
      s_wr_q  <= s_wr_d;
      s_wd_q  <= s_wd_d;
    end
  end

  logic multi;
  logic eff_bs;
  logic eff_hs;
  always_comb begin
    multi  = ($countones(s_be_q) > 1);
    eff_bs = ent.bswap | (ent.mbswap & multi);
    eff_hs = ent.hswap;
  end

  wmap_swap #(.DATA_W(DATA_W)) u_wswap (
    .d_i  (s_wd_q),
    .be_i (s_be_q),
    .bs_i (eff_bs),
    .hs_i (eff_hs),
    .d_o  (rmt_wdata),
    .be_o (rmt_be)
  );

  always_comb begin
    rmt_valid = s_vld_q & ~ent.inval;
    map_err   = s_vld_q &  ent.inval;
    rmt_addr  = {ent.frame, s_off_q};
    rmt_am    = ent.am;
    rmt_kind  = ent.kind;
    rmt_write = s_wr_q;
  end

  // read return path
  logic              rd_bs_q, rd_bs_d;
  logic              rd_hs_q, rd_hs_d;
  logic              ret_vld_q, ret_vld_d;
  logic [DATA_W-1:0] ret_dat_q, ret_dat_d;
  logic [DATA_W-1:0] ret_sw;
  logic [LANES-1:0]  unused_ret_be;
  logic              err_rd;

  always_comb begin
    rd_bs_d   = (rmt_valid && !s_wr_q) ? eff_bs : rd_bs_q;
    rd_hs_d   = (rmt_valid && !s_wr_q) ? eff_hs : rd_hs_q;
    ret_vld_d = rmt_rvalid;
    ret_dat_d = rmt_rvalid ? ret_sw : ret_dat_q;
  end

  wmap_swap #(.DATA_W(DATA_W)) u_rswap (
    .d_i  (rmt_rdata),
    .be_i ('0),
    .bs_i (rd_bs_q),
    .hs_i (rd_hs_q),
    .d_o  (ret_sw),
    .be_o (unused_ret_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bs_q   <= 1'b0;
      rd_hs_q   <= 1'b0;
      ret_vld_q <= 1'b0;
      ret_dat_q <= '0;
    end else begin
      rd_bs_q   <= rd_bs_d;
      rd_hs_q   <= rd_hs_d;
      ret_vld_q <= ret_vld_d;
      ret_dat_q <= ret_dat_d;
    end
  end

  always_comb begin
    err_rd     = map_err & ~s_wr_q;
    loc_rvalid = err_rd | ret_vld_q;
    loc_rdata  = err_rd ? '1 : ret_dat_q;
  end

  wmap_err_flag u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (map_err),
    .clr_i  (err_clr),
    .flag_o (err_sticky)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rmt_valid || map_err)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rmt_valid && !map_err)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rst_n) |=> (rmt_addr[PAGE_SH-1:0] == $past(req_addr[PAGE_SH-1:0]))); // R1
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |=> err_sticky); // R9
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (map_err && !rmt_write) |-> (loc_rvalid && (loc_rdata == '1))); // R8
  AST_RET_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_rvalid |=> loc_rvalid); // R7
endmodule

// File: tb/sim_wmap_top.sv
module sim_wmap_top;
  localparam int IDX_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_rd = 0, err_clr = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rmt_valid, map_err, rmt_write, rmt_rvalid = 0, loc_rvalid, err_sticky;
  logic [31:0] rmt_addr, rmt_wdata, rmt_rdata = '0, loc_rdata;
  logic [5:0]  rmt_am;
  logic [1:0]  rmt_kind;
  logic [3:0]  rmt_be;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] mdl [16];

  always #5 clk = ~clk;

  wmap_top #(.IDX_W(IDX_W), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_clr(err_clr),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be), .req_write(req_write),
    .req_wdata(req_wdata), .rmt_valid(rmt_valid), .map_err(map_err), .rmt_addr(rmt_addr),
    .rmt_am(rmt_am), .rmt_kind(rmt_kind), .rmt_write(rmt_write), .rmt_be(rmt_be),
    .rmt_wdata(rmt_wdata), .rmt_rvalid(rmt_rvalid), .rmt_rdata(rmt_rdata),
    .loc_rvalid(loc_rvalid), .loc_rdata(loc_rdata), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] d, input bit bs, input bit hs);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int s;
      s = k ^ (bs ? 1 : 0) ^ (hs ? 2 : 0);
      r[8*k +: 8] = d[8*s +: 8];
    end
    return r;
  endfunction

  function automatic logic [3:0] be_lanes(input logic [3:0] b, input bit bs, input bit hs);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = b[k ^ (bs ? 1 : 0) ^ (hs ? 2 : 0)];
    return r;
  endfunction

  task automatic write_entry(input int idx, input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = IDX_W'(idx); cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    mdl[idx] = v;
  endtask

  // one access; checks against the model entry e
  task automatic access(input int page, input logic [31:0] e, input logic [3:0] be,
                        input bit wr, input logic [31:0] wd);
    logic [31:0] a;
    bit bs, hs;
    a = $urandom;
    a[21:16] = 6'd0;
    a[15:12] = page[3:0];
    bs = e[3] | (e[1] & ($countones(be) > 1));
    hs = e[2];
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (e[0]) begin
      chk(map_err == 1'b1, "R3 err pulse", 32'(map_err), 32'd1);
      chk(rmt_valid == 1'b0, "R3 blocked", 32'(rmt_valid), 32'd0);
      if (!wr) begin
        chk(loc_rvalid == 1'b1, "R8 rvalid", 32'(loc_rvalid), 32'd1);
        chk(loc_rdata == 32'hFFFF_FFFF, "R8 ones", loc_rdata, 32'hFFFF_FFFF);
      end
      @(negedge clk);
      chk(map_err == 1'b0, "R3 one cycle", 32'(map_err), 32'd0);
      chk(err_sticky == 1'b1, "R9 set", 32'(err_sticky), 32'd1);
      err_clr = 1;
      @(negedge clk);
      err_clr = 0;
      chk(err_sticky == 1'b0, "R9 clear", 32'(err_sticky), 32'd0);
    end else begin
      chk(rmt_valid == 1'b1 && map_err == 1'b0, "R3 valid", {rmt_valid, map_err}, 2'b10);
      chk(rmt_addr == {e[31:12], a[11:0]}, "R1 addr", rmt_addr, {e[31:12], a[11:0]});
      chk(rmt_am == e[11:6], "R4 am", 32'(rmt_am), 32'(e[11:6]));
      chk(rmt_kind == e[5:4], "R5 kind", 32'(rmt_kind), 32'(e[5:4]));
      chk(rmt_write == wr, "R2 dir", 32'(rmt_write), 32'(wr));
      if (wr) begin
        chk(rmt_wdata == lanes(wd, bs, hs), "R6 wdata", rmt_wdata, lanes(wd, bs, hs));
        chk(rmt_be == be_lanes(be, bs, hs), "R6 be", 32'(rmt_be), 32'(be_lanes(be, bs, hs)));
      end else begin
        logic [31:0] rd;
        rd = $urandom;
        @(negedge clk);
        rmt_rvalid = 1; rmt_rdata = rd;
        @(negedge clk);
        rmt_rvalid = 0;
        chk(loc_rvalid == 1'b1, "R7 rvalid", 32'(loc_rvalid), 32'd1);
        chk(loc_rdata == lanes(rd, bs, hs), "R7 rdata", loc_rdata, lanes(rd, bs, hs));
      end
    end
  endtask

  function automatic logic [3:0] pick_be();
    int m;
    m = $urandom % 4;
    if (m == 0) return 4'b0001 << ($urandom % 4);
    if (m == 1) return ($urandom % 2) ? 4'b1100 : 4'b0011;
    return 4'hF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rmt_valid == 0 && map_err == 0, "R3 reset outputs", {rmt_valid, map_err}, 0);
    chk(err_sticky == 0 && loc_rvalid == 0, "R9 reset flag", {err_sticky, loc_rvalid}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      e = $urandom;
      if ($urandom % 5 != 0) e[0] = 1'b0;
      write_entry(i, e);
    end
    // R10 readback
    @(negedge clk);
    cfg_rd = 1; cfg_idx = 10'd5;
    @(negedge clk);
    cfg_rd = 0;
    chk(cfg_rdata == mdl[5], "R10 readback", cfg_rdata, mdl[5]);
    // R6 directed: every swap combination against every enable shape
    for (int s = 0; s < 8; s++) begin
      e = 32'h1234_5000 | (32'(s) << 1) | 32'h0000_0A60;
      write_entry(6, e);
      access(6, e, 4'b0100, 1, 32'hA1B2_C3D4);
      access(6, e, 4'b0011, 1, 32'hA1B2_C3D4);
      access(6, e, 4'hF, 1, 32'hA1B2_C3D4);
      access(6, e, 4'hF, 0, 32'h0);
    end
    // R8 / R3 directed invalid read and write
    write_entry(7, 32'hDEAD_B001);
    access(7, mdl[7], 4'hF, 0, 32'h0);
    access(7, mdl[7], 4'h1, 1, 32'h55);
    // R9 clear coinciding with error: set wins
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_7000; req_be = 4'hF; req_write = 1;
    @(negedge clk);
    req_valid = 0; err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(err_sticky == 1'b1, "R9 set wins", 32'(err_sticky), 32'd1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    chk(err_sticky == 1'b0, "R9 clear after", 32'(err_sticky), 32'd0);
    // R10 same-cycle write and lookup of one page
    write_entry(3, 32'h1111_1010);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 10'd3; cfg_wdata = 32'h2222_2020;
    req_valid = 1; req_addr = 32'h0000_3ABC; req_be = 4'hF; req_write = 0;
    @(negedge clk);
    cfg_wr = 0; req_valid = 0;
    chk(rmt_addr == 32'h1111_1ABC, "R10 old entry", rmt_addr, 32'h1111_1ABC);
    mdl[3] = 32'h2222_2020;
    access(3, mdl[3], 4'hF, 1, 32'h0BAD_F00D);
    // random traffic
    for (int i = 0; i < 300; i++) begin
      int p;
      p = $urandom % 16;
      if ($urandom % 20 == 0) begin
        e = $urandom;
        if ($urandom % 4 != 0) e[0] = 1'b0;
        write_entry(p, e);
      end
      access(p, mdl[p], pick_be(), bit'($urandom % 2), $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule